// File: doc/BRIEF.md
# Masked Vector Expand Unit

This block takes a packed run of 32-bit elements and spreads it across the lanes of a vector result that a per-lane mask selects. Lanes are visited from lane 0 upward. Each selected lane takes the next source element that has not yet been used, so source element 0 lands in the lowest selected lane, element 1 in the next selected lane, and so on. An unselected lane takes one of two values: its old value from the previous destination vector (merge mode) or zero (zeroing mode). If the mask is disabled, every active lane is selected and the result is a plain copy of the low source lanes.

A two-bit width code selects an active width of 4, 8 or 16 lanes. Every bit of the result above the active width is zero. Each operation also carries a 4-bit reserved specifier field. If that field is not all ones, the operation is flagged as illegal and the stored result is not updated. A result, with its valid strobe or its illegal strobe, appears one clock after the input strobe.

Top module: `vexp_expand_unit`

## Requirements
- R1: While rst_ni is low and right after it is released, result_o is zero and valid_o and illegal_o are low.
- R2: Among the active lanes, lane j with its mask bit set receives source element number c, where c is the count of set mask bits in lanes 0..j-1 (element c occupies src_i bits 32c+31:32c).
- R3: With mask_en_i=1 and zero_en_i=0, an active lane whose mask bit is clear takes the same lane of prev_i.
- R4: With mask_en_i=1 and zero_en_i=1, an active lane whose mask bit is clear is zero.
- R5: With mask_en_i=0, all active lanes take source elements 0..n-1 in order, whatever mask_i and zero_en_i hold.
- R6: vlen_i code 0 selects 4 lanes, code 1 selects 8 lanes, and codes 2 and 3 select 16 lanes. Every result lane at or above the active count is zero.
- R7: Mask bits at or above the active lane count have no effect on the result.
- R8: A strobe with rsv_i not equal to 4'b1111 raises illegal_o for one cycle on the next clock, keeps valid_o low and leaves result_o unchanged.
- R9: A legal strobe raises valid_o on the next clock with the new result. In a cycle without a strobe, valid_o falls on the next clock and result_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| rsv_i | input | 4 | Reserved specifier field, must be 4'b1111 |
| vlen_i | input | 2 | Width code: 0 = 4 lanes, 1 = 8 lanes, 2 or 3 = 16 lanes |
| mask_en_i | input | 1 | Apply mask_i when high; select all lanes when low |
| zero_en_i | input | 1 | Unselected lanes are zeroed (1) or merged from prev_i (0) |
| mask_i | input | 16 | Per-lane select, bit j for lane j |
| src_i | input | 512 | Packed source elements, element 0 in the low bits |
| prev_i | input | 512 | Previous destination vector used for merging |
| valid_o | output | 1 | Result updated this cycle |
| illegal_o | output | 1 | Strobe rejected because of the reserved field |
| result_o | output | 512 | Registered expanded vector |

## Verification
The routing path that is hardest to reach is the one to a high lane from a source index far below it. Lane 15 fed from element 1, for example, needs the mask set only at the two ends of the vector. The 16-lane sweep steps through mask values with an odd stride, adds explicit patterns with only the end bits set, and covers every mask exhaustively at 4 and 8 lanes. Set bits above the active width are also driven, to check that they are ignored. Illegal strobes are placed right after legal ones, so that the held result would show any stray write.

// File: rtl/vexp_pkg.sv
package vexp_pkg;
  typedef enum logic [1:0] {
    VL_X4   = 2'd0,
    VL_X8   = 2'd1,
    VL_X16  = 2'd2,
    VL_X16R = 2'd3
  } vlen_e;

  function automatic int unsigned lane_count(input vlen_e code, input int unsigned max_lanes);
    int unsigned n;
    case (code)
      VL_X4:   n = 4;
      VL_X8:   n = 8;
      default: n = 16;
    endcase
    if (n > max_lanes) n = max_lanes;
    return n;
  endfunction
endpackage

// File: rtl/vexp_lane_enable.sv
module vexp_lane_enable #(
  parameter int unsigned LANES = 16
) (
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic [LANES-1:0] mask_i,
  output logic [LANES-1:0] active_o,
  output logic [LANES-1:0] sel_o
);
  int unsigned n_lanes;

  always_comb n_lanes = vexp_pkg::lane_count(vexp_pkg::vlen_e'(vlen_i), LANES);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign active_o[j] = (32'(j) < n_lanes);
    assign sel_o[j]    = active_o[j] & (mask_en_i ? mask_i[j] : 1'b1);
  end
endmodule

// File: rtl/vexp_prefix_count.sv
module vexp_prefix_count #(
  parameter int unsigned LANES = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]            sel_i,
  output logic [LANES-1:0][CNT_W-1:0] idx_o
);
  // exclusive prefix count: idx[j] = ones in sel[j-1:0]
  for (genvar j = 0; j < LANES; j++) begin : g_pfx
    always_comb begin
      idx_o[j] = '0;
      for (int k = 0; k < j; k++) idx_o[j] = idx_o[j] + CNT_W'(sel_i[k]);
    end
  end
endmodule

// File: rtl/vexp_lane_xbar.sv
module vexp_lane_xbar #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 16,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0][LANE_W-1:0] src_i,
  input  logic [LANES-1:0][LANE_W-1:0] prev_i,
  input  logic [LANES-1:0]             active_i,
  input  logic [LANES-1:0]             sel_i,
  input  logic [LANES-1:0][CNT_W-1:0]  idx_i,
  input  logic                         zero_i,
  output logic [LANES-1:0][LANE_W-1:0] res_o
);
  for (genvar j = 0; j < LANES; j++) begin : g_xb
    logic [LANE_W-1:0] picked;

    // lane j can only draw from elements 0..j
    always_comb begin
      picked = '0;
      for (int k = 0; k <= j; k++)
        if (idx_i[j] == CNT_W'(k)) picked = src_i[k];
    end

    always_comb begin
      if (!active_i[j])   res_o[j] = '0;
      else if (sel_i[j])  res_o[j] = picked;
      else if (zero_i)    res_o[j] = '0;
      else                res_o[j] = prev_i[j];
    end
  end
endmodule

// File: rtl/vexp_expand_unit.sv
module vexp_expand_unit #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 16,
  parameter int unsigned RSV_W  = 4,
  localparam int unsigned VEC_W = LANE_W * LANES,
  localparam int unsigned CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [RSV_W-1:0] rsv_i,
  input  logic [1:0]       vlen_i,
  input  logic             mask_en_i,
  input  logic             zero_en_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [VEC_W-1:0] src_i,
  input  logic [VEC_W-1:0] prev_i,
  output logic             valid_o,
  output logic             illegal_o,
  output logic [VEC_W-1:0] result_o
);
  logic [LANES-1:0]             active, sel;
  logic [LANES-1:0][CNT_W-1:0]  idx;
  logic [LANES-1:0][LANE_W-1:0] src_w, prev_w, res_w;
  logic                         legal;
  logic                         valid_q, illegal_q;
  logic [VEC_W-1:0]             result_q;

  assign legal  = (rsv_i == '1);
  assign src_w  = src_i;
  assign prev_w = prev_i;

  vexp_lane_enable #(.LANES(LANES)) u_en (
    .vlen_i    (vlen_i),
    .mask_en_i (mask_en_i),
    .mask_i    (mask_i),
    .active_o  (active),
    .sel_o     (sel)
  );

  vexp_prefix_count #(.LANES(LANES)) u_pfx (
    .sel_i (sel),
    .idx_o (idx)
  );

  vexp_lane_xbar #(.LANE_W(LANE_W), .LANES(LANES)) u_xbar (
    .src_i    (src_w),
    .prev_i   (prev_w),
    .active_i (active),
    .sel_i    (sel),
    .idx_i    (idx),
    .zero_i   (mask_en_i & zero_en_i),
    .res_o    (res_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      result_q  <= '0;
    end else begin
      valid_q   <= valid_i & legal;
      illegal_q <= valid_i & ~legal;
      if (valid_i && legal) result_q <= res_w;
    end
  end

  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign result_o  = result_q;
endmodule

// File: rtl/vexp_expand_chk.sv
module vexp_expand_chk #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned LANES  = 16,
  parameter int unsigned RSV_W  = 4,
  localparam int unsigned VEC_W = LANE_W * LANES
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [RSV_W-1:0] rsv_i,
  input logic [1:0]       vlen_i,
  input logic             mask_en_i,
  input logic             zero_en_i,
  input logic [LANES-1:0] mask_i,
  input logic [VEC_W-1:0] src_i,
  input logic [VEC_W-1:0] prev_i,
  input logic             valid_o,
  input logic             illegal_o,
  input logic [VEC_W-1:0] result_o
);
  logic ok_req;
  assign ok_req = valid_i && (rsv_i == '1);

  // R9
  legal_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_req |=> valid_o && !illegal_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && !illegal_o && $stable(result_o));

  // R8
  illegal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rsv_i != '1) |=> illegal_o && !valid_o && $stable(result_o));

  // R4
  zero_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_req && mask_en_i && zero_en_i && mask_i == '0) |=> result_o == '0);

  // R3
  merge_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_req && mask_en_i && !zero_en_i && mask_i == '0 && vlen_i[1]) |=> result_o == $past(prev_i));

  // R5
  copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ok_req && !mask_en_i && vlen_i[1]) |=> result_o == $past(src_i));

  if (LANES > 8) begin : g_w8
    // R6
    upper_x8_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_req && vlen_i == 2'd1) |=> result_o[VEC_W-1:8*LANE_W] == '0);
  end
  if (LANES > 4) begin : g_w4
    // R6
    upper_x4_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ok_req && vlen_i == 2'd0) |=> result_o[VEC_W-1:4*LANE_W] == '0);
  end
endmodule

bind vexp_expand_unit vexp_expand_chk #(.LANE_W(LANE_W), .LANES(LANES), .RSV_W(RSV_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .rsv_i     (rsv_i),
  .vlen_i    (vlen_i),
  .mask_en_i (mask_en_i),
  .zero_en_i (zero_en_i),
  .mask_i    (mask_i),
  .src_i     (src_i),
  .prev_i    (prev_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .result_o  (result_o)
);

// File: tb/tb_vexp_expand_unit.sv
module tb_vexp_expand_unit;
  localparam int W = 512;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [3:0]   rsv_i = 4'hF;
  logic [1:0]   vlen_i = '0;
  logic         mask_en_i = 1'b0;
  logic         zero_en_i = 1'b0;
  logic [15:0]  mask_i = '0;
  logic [W-1:0] src_i = '0;
  logic [W-1:0] prev_i = '0;
  logic         valid_o, illegal_o;
  logic [W-1:0] result_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] held = '0;

  always #10 clk_i = ~clk_i;

  vexp_expand_unit dut (.*);

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] rnd_vec();
    logic [W-1:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [W-1:0] model(input logic [1:0] vl, input logic [15:0] m,
                                         input bit men, input bit zen,
                                         input logic [W-1:0] s, input logic [W-1:0] p);
    logic [W-1:0] r;
    int n, k;
    n = (vl == 2'd0) ? 4 : (vl == 2'd1) ? 8 : 16;
    r = '0;
    k = 0;
    for (int j = 0; j < n; j++) begin
      if (!men || m[j]) begin
        r[j*32 +: 32] = s[k*32 +: 32];
        k++;
      end else if (!zen) begin
        r[j*32 +: 32] = p[j*32 +: 32];
      end
    end
    return r;
  endfunction

  // called at a falling edge; checks at the next falling edge
  task automatic xact(input logic [1:0] vl, input logic [15:0] m, input bit men,
                      input bit zen, input logic [3:0] rsv, input string req);
    logic [W-1:0] exp;
    bit legal;
    src_i     = rnd_vec();
    prev_i    = rnd_vec();
    vlen_i    = vl;
    mask_i    = m;
    mask_en_i = men;
    zero_en_i = zen;
    rsv_i     = rsv;
    valid_i   = 1'b1;
    legal     = (rsv == 4'hF);
    exp       = legal ? model(vl, m, men, zen, src_i, prev_i) : held;
    @(negedge clk_i);
    chk(valid_o == legal, {req, " valid_o"}, W'(valid_o), W'(legal));
    chk(illegal_o == !legal, {req, " illegal_o"}, W'(illegal_o), W'(!legal));
    chk(result_o == exp, {req, " result_o"}, result_o, exp);
    held = exp;
  endtask

  task automatic idle(input string req);
    valid_i = 1'b0;
    src_i   = rnd_vec();
    prev_i  = rnd_vec();
    @(negedge clk_i);
    chk(!valid_o && !illegal_o, {req, " idle strobes"}, W'({valid_o, illegal_o}), '0);
    chk(result_o == held, {req, " idle hold"}, result_o, held);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 during reset
    chk(result_o == '0 && !valid_o && !illegal_o, "R1 in reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 after release
    chk(result_o == '0 && !valid_o && !illegal_o, "R1 after release", result_o, '0);

    // R2 R3 R4 R7: 4 lanes, all masks, upper mask bits random
    for (int m = 0; m < 16; m++)
      for (int z = 0; z < 2; z++)
        xact(2'd0, {12'($urandom), 4'(m)}, 1'b1, z[0], 4'hF, z ? "R4 R7 x4" : "R3 R7 x4");
    // R2 R7: 8 lanes, all masks
    for (int m = 0; m < 256; m++)
      for (int z = 0; z < 2; z++)
        xact(2'd1, {8'($urandom), 8'(m)}, 1'b1, z[0], 4'hF, "R2 R7 x8");
    // R2: 16 lanes, strided sweep plus end patterns
    for (int i = 0; i < 1024; i++)
      xact(2'd2, 16'(i * 16'd97 + 16'd13), 1'b1, i[0], 4'hF, "R2 x16");
    xact(2'd2, 16'h8001, 1'b1, 1'b1, 4'hF, "R2 ends");
    xact(2'd2, 16'h8000, 1'b1, 1'b0, 4'hF, "R2 top only");
    xact(2'd2, 16'hFFFF, 1'b1, 1'b0, 4'hF, "R2 full");
    xact(2'd2, 16'h0000, 1'b1, 1'b0, 4'hF, "R3 none merge");
    xact(2'd2, 16'h0000, 1'b1, 1'b1, 4'hF, "R4 none zero");
    // R5: mask disabled
    for (int v = 0; v < 4; v++)
      for (int i = 0; i < 8; i++)
        xact(2'(v), 16'($urandom), 1'b0, i[0], 4'hF, "R5 copy");
    // R6: width code 3 and narrow widths with a full mask
    for (int i = 0; i < 16; i++)
      xact(2'd3, 16'($urandom), 1'b1, i[0], 4'hF, "R6 code3");
    xact(2'd0, 16'hFFFF, 1'b1, 1'b0, 4'hF, "R6 x4 upper zero");
    xact(2'd1, 16'hFFFF, 1'b1, 1'b0, 4'hF, "R6 x8 upper zero");
    // R8: illegal reserved values right after legal ones
    for (int r = 0; r < 15; r++) begin
      xact(2'd2, 16'($urandom), 1'b1, 1'b0, 4'hF, "R9 legal");
      xact(2'(r), 16'($urandom), r[0], r[1], 4'(r), "R8 illegal");
    end
    // R9: idle cycles keep the result
    idle("R9");
    idle("R9");
    xact(2'd1, 16'h00A5, 1'b1, 1'b0, 4'hF, "R9 resume");
    idle("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule